// File: doc/BRIEF.md
# Address Table Maintenance Scan Engine

This block walks a forwarding address table one index per step and carries out maintenance commands on it. A host-side controller loads a command and its arguments, raises `start` for one cycle, and waits for `done`. The engine then reads each table entry through a synchronous read port. It decides whether the entry matches or must change, and writes the changed entry back on the next cycle through the same address bus. At the end it pulses `done` together with a `found` flag and a result index.

The commands are: look up an address under a VLAN, find the first free slot, find the first ageable slot, add a unicast entry, flush entries belonging to a set of ports, flush multicast entries (optionally only within one VLAN), and set or clear the all-multicast flag in every VLAN entry. Hardware learning and aging timers are not part of the block. Entries are 72 bits wide. Bits 71:69 are unused and are written back unchanged.

Top module: `tbl_scan_engine`

## Requirements
- R1: While reset is asserted and directly after it, `busy`, `done`, `tblRdEn` and `tblWrEn` are low.
- R2: `done` is high for exactly one cycle per accepted command. A `start` seen while `busy` is high is ignored and has no effect on the table or the result.
- R3: Each entry costs two cycles: a read cycle (`tblRdEn` high) and an evaluate cycle, which writes the entry back at the same address only if its content changed. A full 16-entry scan that stops on nothing raises `done` 33 cycles after the cycle `start` was sampled. Read and write are never active together.
- R4: Lookup (cmd 0) returns the lowest index whose type (bits 61:60) is 1 or 3, whose VLAN id (bits 59:48) equals `keyVid`, and whose MAC (bits 47:0, first byte in 47:40) equals `keyMac`. With no such index, `found`=0 and the index is 0.
- R5: Free search (cmd 1) returns the lowest index whose type field is 0.
- R6: Ageable search (cmd 2) returns the lowest entry that meets all of these: type 1 or 3, bit 40 clear, and unicast kind (bits 63:62) neither 0 (persistent) nor 2 (vendor-prefix).
- R7: Add-unicast (cmd 3) writes to the matching entry if there is one, otherwise to the lowest free entry, otherwise to the lowest ageable entry. If none exists it writes nothing and reports `found`=0.
- R8: A written unicast entry is all zero except for these fields: type 3 with VLAN id `keyVid` when `useVlan`=1, otherwise type 1 with VLAN id 0; MAC `keyMac`; secure bit 64 = `ucSecure`; blocked bit 65 = `ucBlocked`; port bits 67:66 = `ucPort`. The match key for the add uses that same VLAN id.
- R9: Port flush (cmd 4) applies to entries of type 1 or 3. A unicast entry (bit 40 clear) whose port bit is set in `portMask` becomes free (type set to 0). A multicast entry (bit 40 set) that shares a bit with `portMask` loses those bits from its port mask (bits 68:66), and becomes free instead if that mask reaches zero.
- R10: Multicast flush (cmd 5) applies the multicast rule of R9 only to entries of type 1 or 3 with bit 40 set and a MAC that is not all ones. With `vidFilter` = 0xFFF every VLAN is affected; otherwise only entries whose VLAN id equals `vidFilter`.
- R11: All-multicast (cmd 6) sets or clears bit 8 (the low bit of the unregistered-multicast field 10:8) of every type-2 entry to `allMultiOn`. If `allMultiOn` equals the last stored setting (0 after reset), the command completes with `done` one cycle after `start` and touches no entry.
- R12: For flush and all-multicast commands `found` reports whether any entry was written; the index is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Command request, sampled when idle |
| cmd | input | 3 | Command code 0..6 |
| keyMac | input | 48 | MAC key for lookup and add |
| keyVid | input | 12 | VLAN key for lookup and add |
| useVlan | input | 1 | Add: store as VLAN-qualified entry |
| ucPort | input | 2 | Add: port number |
| ucSecure | input | 1 | Add: secure flag |
| ucBlocked | input | 1 | Add: blocked flag |
| portMask | input | 3 | Flush: ports to remove |
| vidFilter | input | 12 | Multicast flush VLAN filter, 0xFFF for all |
| allMultiOn | input | 1 | All-multicast requested setting |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| found | output | 1 | Result flag, valid with done |
| resultIdx | output | IdxW | Result index, valid with done |
| tblRdEn | output | 1 | Table read request |
| tblWrEn | output | 1 | Table write strobe |
| tblAddr | output | IdxW | Table address for read and write |
| tblRdData | input | 72 | Table read data, one cycle after tblRdEn |
| tblWrData | output | 72 | Table write data |

## Verification
A corrupted scan index or a stale latched argument shows up at the next `done` of that command as a wrong index or flag, or as a table entry that differs from the predicted image. Such a fault is visible within one scan of 33 cycles. A mistake in the write-back decision leaves a wrong table entry, or a write where none should happen, at the evaluate cycle of that entry. Losing the stored all-multicast setting shows at once as a full-length scan instead of a one-cycle completion. A start accepted while busy shows as a second `done` pulse or as flushed entries.

// File: rtl/tbl_scan_pkg.sv
package tbl_scan_pkg;
  localparam int EntryW = 72;
  localparam int MacW = 48;
  localparam int VidW = 12;
  localparam int PortMaskW = 3;

  typedef enum logic [2:0] {
    CMD_LOOKUP   = 3'd0,
    CMD_FREE     = 3'd1,
    CMD_AGEABLE  = 3'd2,
    CMD_ADD      = 3'd3,
    CMD_FLUSH    = 3'd4,
    CMD_MFLUSH   = 3'd5,
    CMD_ALLMULTI = 3'd6,
    CMD_NONE     = 3'd7
  } cmd_e;

  typedef enum logic [2:0] {
    S_IDLE, S_READ, S_EVAL, S_COMMIT, S_FIN
  } state_e;

  // control -> datapath strobes
  typedef struct packed {
    logic latch;     // capture command and arguments
    logic useFresh;  // drive the built unicast entry on the write bus
  } strobe_t;

  localparam logic [1:0] TypeFree     = 2'd0;
  localparam logic [1:0] TypeAddr     = 2'd1;
  localparam logic [1:0] TypeVlan     = 2'd2;
  localparam logic [1:0] TypeVlanAddr = 2'd3;
  localparam logic [1:0] UcPersist    = 2'd0;
  localparam logic [1:0] UcVendor     = 2'd2;
endpackage

// File: rtl/tbl_scan_dp.sv
module tbl_scan_dp
  import tbl_scan_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strb,
  input  logic [2:0]           cmdIn,
  input  logic [MacW-1:0]      keyMac,
  input  logic [VidW-1:0]      keyVid,
  input  logic                 useVlan,
  input  logic [1:0]           ucPort,
  input  logic                 ucSecure,
  input  logic                 ucBlocked,
  input  logic [PortMaskW-1:0] portMask,
  input  logic [VidW-1:0]      vidFilter,
  input  logic                 allMultiOn,
  input  logic [EntryW-1:0]    rdData,
  output cmd_e                 cmdQ,
  output logic                 amSame,
  output logic                 isMatch,
  output logic                 isFree,
  output logic                 isAgeable,
  output logic                 wrNeeded,
  output logic [EntryW-1:0]    wrData
);
  localparam logic [VidW-1:0] VidAll = '1;
  localparam logic [MacW-1:0] MacBcast = '1;

  logic [MacW-1:0]      macQ;
  logic [VidW-1:0]      vidQ;
  logic [VidW-1:0]      vfQ;
  logic                 useVlanQ;
  logic [1:0]           portQ;
  logic                 secQ;
  logic                 blkQ;
  logic [PortMaskW-1:0] maskQ;
  logic                 amValQ;
  logic                 amState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdQ     <= CMD_LOOKUP;
      macQ     <= '0;
      vidQ     <= '0;
      vfQ      <= '0;
      useVlanQ <= 1'b0;
      portQ    <= '0;
      secQ     <= 1'b0;
      blkQ     <= 1'b0;
      maskQ    <= '0;
      amValQ   <= 1'b0;
      amState  <= 1'b0;
    end else if (strb.latch) begin
      cmdQ     <= cmd_e'(cmdIn);
      macQ     <= keyMac;
      vidQ     <= (cmd_e'(cmdIn) == CMD_ADD && !useVlan) ? '0 : keyVid;
      vfQ      <= vidFilter;
      useVlanQ <= useVlan;
      portQ    <= ucPort;
      secQ     <= ucSecure;
      blkQ     <= ucBlocked;
      maskQ    <= portMask;
      amValQ   <= allMultiOn;
      if (cmd_e'(cmdIn) == CMD_ALLMULTI) amState <= allMultiOn;
    end
  end

  assign amSame = (cmd_e'(cmdIn) == CMD_ALLMULTI) && (allMultiOn == amState);

  // field views of the entry being evaluated
  logic [1:0]           eType;
  logic [VidW-1:0]      eVid;
  logic [MacW-1:0]      eMac;
  logic                 eMulti;
  logic [1:0]           eUcKind;
  logic [1:0]           ePort;
  logic                 eIsAddr;
  logic [3:0]           maskWide;
  logic [EntryW-1:0]    nextEntry;
  logic [EntryW-1:0]    freshEntry;

  assign eType    = rdData[61:60];
  assign eVid     = rdData[59:48];
  assign eMac     = rdData[47:0];
  assign eMulti   = rdData[40];
  assign eUcKind  = rdData[63:62];
  assign ePort    = rdData[67:66];
  assign eIsAddr  = (eType == TypeAddr) || (eType == TypeVlanAddr);
  assign maskWide = {1'b0, maskQ};

  assign isMatch   = eIsAddr && (eVid == vidQ) && (eMac == macQ);
  assign isFree    = (eType == TypeFree);
  assign isAgeable = eIsAddr && !eMulti && (eUcKind != UcPersist) && (eUcKind != UcVendor);

  function automatic logic [EntryW-1:0] shrinkMulti(logic [EntryW-1:0] e, logic [PortMaskW-1:0] m);
    logic [EntryW-1:0]    r;
    logic [PortMaskW-1:0] left;
    r    = e;
    left = e[68:66] & ~m;
    if ((e[68:66] & m) != '0) begin
      if (left == '0) r[61:60] = TypeFree;
      else            r[68:66] = left;
    end
    return r;
  endfunction

  always_comb begin
    nextEntry = rdData;
    case (cmdQ)
      CMD_FLUSH: begin
        if (eIsAddr) begin
          if (eMulti)                nextEntry = shrinkMulti(rdData, maskQ);
          else if (maskWide[ePort])  nextEntry[61:60] = TypeFree;
        end
      end
      CMD_MFLUSH: begin
        if (eIsAddr && eMulti && (eMac != MacBcast) && (vfQ == VidAll || eVid == vfQ))
          nextEntry = shrinkMulti(rdData, maskQ);
      end
      CMD_ALLMULTI: begin
        if (eType == TypeVlan) nextEntry[8] = amValQ;
      end
      default: nextEntry = rdData;
    endcase
  end

  always_comb begin
    freshEntry         = '0;
    freshEntry[61:60]  = useVlanQ ? TypeVlanAddr : TypeAddr;
    freshEntry[59:48]  = vidQ;
    freshEntry[47:0]   = macQ;
    freshEntry[63:62]  = UcPersist;
    freshEntry[64]     = secQ;
    freshEntry[65]     = blkQ;
    freshEntry[67:66]  = portQ;
  end

  assign wrNeeded = (nextEntry != rdData);
  assign wrData   = strb.useFresh ? freshEntry : nextEntry;

  // R11: the all-multicast edit changes only the unregistered-multicast low bit
  a_r11_only_unreg_bit: assert property (@(posedge clk) disable iff (!rstN)
    (wrNeeded && cmdQ == CMD_ALLMULTI) |-> ((nextEntry ^ rdData) == (EntryW'(1) << 8)));

  // R9: a port flush either frees the entry or leaves a nonzero mask of the same type
  a_r9_free_or_shrink: assert property (@(posedge clk) disable iff (!rstN)
    (wrNeeded && cmdQ == CMD_FLUSH) |->
      (nextEntry[61:60] == TypeFree) || (nextEntry[68:66] != '0 && nextEntry[61:60] == eType));

  // R2: arguments latched for a running command stay put when start repeats
  a_r2_args_held: assert property (@(posedge clk) disable iff (!rstN)
    (strb.latch == 1'b0) |=> $stable(cmdQ) && $stable(maskQ));
endmodule

// File: rtl/tbl_scan_ctrl.sv
module tbl_scan_ctrl
  import tbl_scan_pkg::*;
#(
  parameter int Depth = 64,
  parameter int IdxW  = 6
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  cmd_e            cmdQ,
  input  logic            amSame,
  input  logic            isMatch,
  input  logic            isFree,
  input  logic            isAgeable,
  input  logic            wrNeeded,
  output strobe_t         strb,
  output logic            busy,
  output logic            done,
  output logic            found,
  output logic [IdxW-1:0] resultIdx,
  output logic            tblRdEn,
  output logic            tblWrEn,
  output logic [IdxW-1:0] tblAddr
);
  localparam logic [IdxW-1:0] LastIdx = IdxW'(Depth - 1);

  state_e          state;
  logic [IdxW-1:0] idx;
  logic [IdxW-1:0] slotQ;
  logic [IdxW-1:0] freeIdx;
  logic [IdxW-1:0] ageIdx;
  logic            haveFree;
  logic            haveAge;
  logic            anyWr;
  logic            probeHit;
  logic            atLast;

  assign atLast = (idx == LastIdx);

  always_comb begin
    case (cmdQ)
      CMD_LOOKUP:  probeHit = isMatch;
      CMD_FREE:    probeHit = isFree;
      CMD_AGEABLE: probeHit = isAgeable;
      default:     probeHit = 1'b0;
    endcase
  end

  always_comb begin
    strb.latch    = (state == S_IDLE) && start;
    strb.useFresh = (state == S_COMMIT);
    tblRdEn       = (state == S_READ);
    tblWrEn       = (state == S_COMMIT) || ((state == S_EVAL) && wrNeeded);
    tblAddr       = (state == S_COMMIT) ? slotQ : idx;
  end

  assign busy = (state != S_IDLE);
  assign done = (state == S_FIN);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      idx       <= '0;
      slotQ     <= '0;
      freeIdx   <= '0;
      ageIdx    <= '0;
      haveFree  <= 1'b0;
      haveAge   <= 1'b0;
      anyWr     <= 1'b0;
      found     <= 1'b0;
      resultIdx <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (start) begin
            if (amSame) begin
              found     <= 1'b0;
              resultIdx <= '0;
              state     <= S_FIN;
            end else begin
              idx      <= '0;
              haveFree <= 1'b0;
              haveAge  <= 1'b0;
              anyWr    <= 1'b0;
              state    <= S_READ;
            end
          end
        end
        S_READ: state <= S_EVAL;
        S_EVAL: begin
          case (cmdQ)
            CMD_LOOKUP, CMD_FREE, CMD_AGEABLE: begin
              if (probeHit) begin
                found     <= 1'b1;
                resultIdx <= idx;
                state     <= S_FIN;
              end else if (atLast) begin
                found     <= 1'b0;
                resultIdx <= '0;
                state     <= S_FIN;
              end else begin
                idx   <= idx + 1'b1;
                state <= S_READ;
              end
            end
            CMD_ADD: begin
              if (isMatch) begin
                slotQ <= idx;
                state <= S_COMMIT;
              end else begin
                if (isFree && !haveFree) begin
                  haveFree <= 1'b1;
                  freeIdx  <= idx;
                end
                if (isAgeable && !haveAge) begin
                  haveAge <= 1'b1;
                  ageIdx  <= idx;
                end
                if (atLast) begin
                  if (haveFree || isFree) begin
                    slotQ <= haveFree ? freeIdx : idx;
                    state <= S_COMMIT;
                  end else if (haveAge || isAgeable) begin
                    slotQ <= haveAge ? ageIdx : idx;
                    state <= S_COMMIT;
                  end else begin
                    found     <= 1'b0;
                    resultIdx <= '0;
                    state     <= S_FIN;
                  end
                end else begin
                  idx   <= idx + 1'b1;
                  state <= S_READ;
                end
              end
            end
            default: begin
              anyWr <= anyWr | wrNeeded;
              if (atLast) begin
                found     <= anyWr | wrNeeded;
                resultIdx <= '0;
                state     <= S_FIN;
              end else begin
                idx   <= idx + 1'b1;
                state <= S_READ;
              end
            end
          endcase
        end
        S_COMMIT: begin
          found     <= 1'b1;
          resultIdx <= slotQ;
          state     <= S_FIN;
        end
        S_FIN:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R2: completion is a single-cycle pulse
  a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R2: a command only begins from a sampled start
  a_r2_busy_needs_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));

  // R3: read and write ports never active together
  a_r3_rd_wr_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(tblRdEn && tblWrEn));

  // R3: evaluation cycle follows a read of the same index
  a_r3_eval_after_read: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_EVAL) |-> ($past(tblRdEn) && tblAddr == $past(tblAddr)));
endmodule

// File: rtl/tbl_scan_engine.sv
module tbl_scan_engine
  import tbl_scan_pkg::*;
#(
  parameter  int Depth = 64,
  localparam int IdxW  = (Depth > 1) ? $clog2(Depth) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [2:0]        cmd,
  input  logic [47:0]       keyMac,
  input  logic [11:0]       keyVid,
  input  logic              useVlan,
  input  logic [1:0]        ucPort,
  input  logic              ucSecure,
  input  logic              ucBlocked,
  input  logic [2:0]        portMask,
  input  logic [11:0]       vidFilter,
  input  logic              allMultiOn,
  output logic              busy,
  output logic              done,
  output logic              found,
  output logic [IdxW-1:0]   resultIdx,
  output logic              tblRdEn,
  output logic              tblWrEn,
  output logic [IdxW-1:0]   tblAddr,
  input  logic [71:0]       tblRdData,
  output logic [71:0]       tblWrData
);
  strobe_t strb;
  cmd_e    cmdQ;
  logic    amSame;
  logic    isMatch;
  logic    isFree;
  logic    isAgeable;
  logic    wrNeeded;

  tbl_scan_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cmdIn(cmd),
    .keyMac(keyMac), .keyVid(keyVid), .useVlan(useVlan),
    .ucPort(ucPort), .ucSecure(ucSecure), .ucBlocked(ucBlocked),
    .portMask(portMask), .vidFilter(vidFilter), .allMultiOn(allMultiOn),
    .rdData(tblRdData), .cmdQ(cmdQ), .amSame(amSame),
    .isMatch(isMatch), .isFree(isFree), .isAgeable(isAgeable),
    .wrNeeded(wrNeeded), .wrData(tblWrData)
  );

  tbl_scan_ctrl #(.Depth(Depth), .IdxW(IdxW)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .cmdQ(cmdQ), .amSame(amSame),
    .isMatch(isMatch), .isFree(isFree), .isAgeable(isAgeable),
    .wrNeeded(wrNeeded), .strb(strb), .busy(busy), .done(done),
    .found(found), .resultIdx(resultIdx), .tblRdEn(tblRdEn),
    .tblWrEn(tblWrEn), .tblAddr(tblAddr)
  );
endmodule

// File: tb/tbl_scan_engine_tb.sv
module tbl_scan_engine_tb;
  localparam int Depth = 16;
  localparam int IdxW  = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rstN;
  logic        start;
  logic [2:0]  cmd;
  logic [47:0] keyMac;
  logic [11:0] keyVid;
  logic        useVlan;
  logic [1:0]  ucPort;
  logic        ucSecure;
  logic        ucBlocked;
  logic [2:0]  portMask;
  logic [11:0] vidFilter;
  logic        allMultiOn;
  logic        busy, done, found, tblRdEn, tblWrEn;
  logic [IdxW-1:0] resultIdx, tblAddr;
  logic [71:0] tblRdData, tblWrData;

  logic [71:0] mem [Depth];
  logic [71:0] img [Depth];
  logic [71:0] expT [Depth];
  logic        loadReq;

  int  checks = 0;
  int  errors = 0;
  bit  refAm = 1'b0;
  bit  eFound;
  int  eIdx;
  int  lat;
  bit  injectBusy = 1'b0;

  tbl_scan_engine #(.Depth(Depth)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .cmd(cmd), .keyMac(keyMac),
    .keyVid(keyVid), .useVlan(useVlan), .ucPort(ucPort), .ucSecure(ucSecure),
    .ucBlocked(ucBlocked), .portMask(portMask), .vidFilter(vidFilter),
    .allMultiOn(allMultiOn), .busy(busy), .done(done), .found(found),
    .resultIdx(resultIdx), .tblRdEn(tblRdEn), .tblWrEn(tblWrEn),
    .tblAddr(tblAddr), .tblRdData(tblRdData), .tblWrData(tblWrData)
  );

  initial tblRdData = '0;
  always @(posedge clk) begin
    if (loadReq) begin
      for (int i = 0; i < Depth; i++) mem[i] <= img[i];
    end else begin
      if (tblRdEn) tblRdData <= mem[tblAddr];
      if (tblWrEn) mem[tblAddr] <= tblWrData;
    end
  end

  task automatic check(bit ok, string tag, logic [71:0] act, logic [71:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // ---------- entry builders ----------
  function automatic logic [71:0] mkUc(logic [1:0] typ, logic [11:0] vid, logic [47:0] mac,
                                       logic [1:0] kind, logic [1:0] port);
    logic [71:0] e = '0;
    e[61:60] = typ; e[59:48] = vid; e[47:0] = mac; e[63:62] = kind; e[67:66] = port;
    return e;
  endfunction

  function automatic logic [71:0] mkMc(logic [11:0] vid, logic [47:0] mac, logic [2:0] pm);
    logic [71:0] e = '0;
    e[61:60] = 2'd1; e[59:48] = vid; e[47:0] = mac; e[40] = 1'b1; e[68:66] = pm;
    return e;
  endfunction

  function automatic logic [71:0] mkVlan(logic [11:0] vid, logic [2:0] unreg);
    logic [71:0] e = '0;
    e[61:60] = 2'd2; e[59:48] = vid; e[10:8] = unreg; e[2:0] = 3'b111;
    return e;
  endfunction

  function automatic logic [47:0] rndMac();
    logic [2:0] k = 3'($urandom % 6);
    if (k == 3'd5) return '1;
    return {7'd0, k[0], 32'd0, 5'd0, k};
  endfunction

  function automatic logic [71:0] rndEntry();
    logic [95:0] r = {$urandom, $urandom, $urandom};
    logic [71:0] e = r[71:0];
    e[71:69] = '0;
    e[59:48] = ($urandom % 2 == 0) ? 12'd5 : 12'd0;
    e[47:0]  = rndMac();
    return e;
  endfunction

  function automatic bit isAddrE(logic [71:0] e);
    return (e[61:60] == 2'd1) || (e[61:60] == 2'd3);
  endfunction

  function automatic bit isAgeE(logic [71:0] e);
    return isAddrE(e) && !e[40] && e[63:62] != 2'd0 && e[63:62] != 2'd2;
  endfunction

  function automatic logic [71:0] mcRule(logic [71:0] e, logic [2:0] m);
    logic [71:0] r = e;
    logic [2:0]  keep = e[68:66] & ~m;
    if ((e[68:66] & m) != 3'd0) begin
      if (keep == 3'd0) r[61:60] = 2'd0;
      else              r[68:66] = keep;
    end
    return r;
  endfunction

  // ---------- reference model from the requirements ----------
  task automatic refCmd();
    logic [71:0] ne, n;
    logic [11:0] v;
    logic [3:0]  m4;
    int slot;
    eFound = 1'b0; eIdx = 0;
    case (cmd)
      3'd0: for (int i = 0; i < Depth; i++)
              if (!eFound && isAddrE(expT[i]) && expT[i][59:48] == keyVid && expT[i][47:0] == keyMac) begin
                eFound = 1'b1; eIdx = i;
              end
      3'd1: for (int i = 0; i < Depth; i++)
              if (!eFound && expT[i][61:60] == 2'd0) begin eFound = 1'b1; eIdx = i; end
      3'd2: for (int i = 0; i < Depth; i++)
              if (!eFound && isAgeE(expT[i])) begin eFound = 1'b1; eIdx = i; end
      3'd3: begin
        v  = useVlan ? keyVid : 12'd0;
        ne = mkUc(useVlan ? 2'd3 : 2'd1, v, keyMac, 2'd0, ucPort);
        ne[64] = ucSecure; ne[65] = ucBlocked;
        slot = -1;
        for (int i = 0; i < Depth; i++)
          if (slot < 0 && isAddrE(expT[i]) && expT[i][59:48] == v && expT[i][47:0] == keyMac) slot = i;
        for (int i = 0; i < Depth; i++)
          if (slot < 0 && expT[i][61:60] == 2'd0) slot = i;
        for (int i = 0; i < Depth; i++)
          if (slot < 0 && isAgeE(expT[i])) slot = i;
        if (slot >= 0) begin expT[slot] = ne; eFound = 1'b1; eIdx = slot; end
      end
      3'd4: begin
        m4 = {1'b0, portMask};
        for (int i = 0; i < Depth; i++) begin
          n = expT[i];
          if (isAddrE(n)) begin
            if (n[40]) n = mcRule(n, portMask);
            else if (m4[n[67:66]]) n[61:60] = 2'd0;
          end
          if (n != expT[i]) eFound = 1'b1;
          expT[i] = n;
        end
      end
      3'd5: for (int i = 0; i < Depth; i++) begin
        n = expT[i];
        if (isAddrE(n) && n[40] && n[47:0] != 48'hFFFF_FFFF_FFFF &&
            (vidFilter == 12'hFFF || n[59:48] == vidFilter)) n = mcRule(n, portMask);
        if (n != expT[i]) eFound = 1'b1;
        expT[i] = n;
      end
      3'd6: if (allMultiOn != refAm) begin
        refAm = allMultiOn;
        for (int i = 0; i < Depth; i++) begin
          n = expT[i];
          if (n[61:60] == 2'd2) n[8] = allMultiOn;
          if (n != expT[i]) eFound = 1'b1;
          expT[i] = n;
        end
      end
      default: ;
    endcase
  endtask

  // ---------- stimulus helpers ----------
  task automatic loadImg();
    for (int i = 0; i < Depth; i++) expT[i] = img[i];
    @(negedge clk); loadReq = 1'b1;
    @(negedge clk); loadReq = 1'b0;
  endtask

  task automatic go(string tag);
    lat = 0;
    @(negedge clk); start = 1'b1;
    do begin
      @(negedge clk);
      start = 1'b0;
      lat++;
      if (injectBusy && lat == 3) begin
        start = 1'b1; cmd = 3'd4; portMask = 3'b111;
      end
    end while (!done && lat < 2000);
    if (lat >= 2000) check(1'b0, {tag, " command never completed"}, 72'(lat), 72'd0);
  endtask

  task automatic runOne(string tag);
    refCmd();
    go(tag);
    check(found == eFound, {tag, " found flag"}, 72'(found), 72'(eFound));
    check(resultIdx == 4'(eIdx), {tag, " result index"}, 72'(resultIdx), 72'(eIdx));
    @(negedge clk);
    check(done == 1'b0, "R2 done lasts one cycle", 72'(done), 72'd0);
    for (int i = 0; i < Depth; i++)
      if (mem[i] !== expT[i]) check(1'b0, {tag, " table entry"}, mem[i], expT[i]);
    checks++;
  endtask

  task automatic clearArgs();
    cmd = 3'd0; keyMac = '0; keyVid = '0; useVlan = 1'b0; ucPort = '0;
    ucSecure = 1'b0; ucBlocked = 1'b0; portMask = '0; vidFilter = '0;
  endtask

  // ---------- watchdog ----------
  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  logic [71:0] want;

  initial begin
    void'($urandom(32'd4242));
    rstN = 1'b0; start = 1'b0; loadReq = 1'b0; allMultiOn = 1'b0;
    clearArgs();
    for (int i = 0; i < Depth; i++) img[i] = '0;
    repeat (3) @(negedge clk);
    check({busy, done, tblRdEn, tblWrEn} == 4'b0, "R1 outputs in reset", 72'({busy, done, tblRdEn, tblWrEn}), 72'd0);
    rstN = 1'b1;
    @(negedge clk);
    check({busy, done, tblRdEn, tblWrEn} == 4'b0, "R1 outputs after reset", 72'({busy, done, tblRdEn, tblWrEn}), 72'd0);

    // R4 R3: full miss on an empty table, exact latency
    loadImg();
    clearArgs(); cmd = 3'd0; keyMac = 48'h0000_0000_0003;
    runOne("R4 lookup miss");
    check(lat == 2 * Depth + 1, "R3 full scan latency", 72'(lat), 72'(2 * Depth + 1));

    // R5: free search skips occupied entries
    for (int i = 0; i < Depth; i++) img[i] = mkUc(2'd1, 12'd0, 48'(i + 100), 2'd0, 2'd0);
    img[6] = mkVlan(12'd3, 3'd0); img[11][61:60] = 2'd0; img[13][61:60] = 2'd0;
    loadImg();
    clearArgs(); cmd = 3'd1;
    runOne("R5 first free");

    // R4: match needs equal VLAN and address type
    img[2] = mkUc(2'd3, 12'd7, 48'h0A0B, 2'd0, 2'd1);
    img[4] = mkUc(2'd3, 12'd9, 48'h0A0B, 2'd0, 2'd1);
    loadImg();
    clearArgs(); cmd = 3'd0; keyMac = 48'h0A0B; keyVid = 12'd9;
    runOne("R4 lookup hit on vid");

    // R8 R7: add into empty table goes to slot 0
    for (int i = 0; i < Depth; i++) img[i] = '0;
    loadImg();
    clearArgs(); cmd = 3'd3; keyMac = 48'h1122_3344_5566; keyVid = 12'd42; useVlan = 1'b1;
    ucPort = 2'd2; ucSecure = 1'b1; ucBlocked = 1'b0;
    runOne("R7 add to free slot");
    want = '0; want[61:60] = 2'd3; want[59:48] = 12'd42; want[47:0] = 48'h1122_3344_5566;
    want[64] = 1'b1; want[67:66] = 2'd2;
    check(mem[0] == want, "R8 written unicast entry", mem[0], want);

    // R6 R7: full table of persistent entries plus two ageable ones
    for (int i = 0; i < Depth; i++) img[i] = mkUc(2'd1, 12'd0, 48'(i + 200), 2'd0, 2'd1);
    img[5]  = mkUc(2'd1, 12'd0, 48'h55, 2'd2, 2'd1);
    img[8]  = mkMc(12'd0, 48'h0100_0000_0008, 3'b011);
    img[9]  = mkUc(2'd1, 12'd0, 48'h99, 2'd1, 2'd1);
    img[12] = mkUc(2'd3, 12'd4, 48'hCC, 2'd3, 2'd0);
    loadImg();
    clearArgs(); cmd = 3'd2;
    runOne("R6 first ageable");
    clearArgs(); cmd = 3'd3; keyMac = 48'hABCD; ucPort = 2'd1;
    runOne("R7 add evicts ageable");
    clearArgs(); cmd = 3'd2;
    runOne("R6 next ageable after eviction");

    // R7: no free and no ageable slot -> error, no write
    for (int i = 0; i < Depth; i++) img[i] = mkUc(2'd1, 12'd0, 48'(i + 300), 2'd0, 2'd0);
    loadImg();
    clearArgs(); cmd = 3'd3; keyMac = 48'hDEAD;
    runOne("R7 table full");

    // R7: an existing match wins over a lower free slot
    img[2] = '0; img[7] = mkUc(2'd1, 12'd0, 48'hBEEF, 2'd0, 2'd0);
    loadImg();
    clearArgs(); cmd = 3'd3; keyMac = 48'hBEEF; ucPort = 2'd3; ucBlocked = 1'b1;
    runOne("R7 match before free");

    // R9 R12 R3: port flush
    for (int i = 0; i < Depth; i++) img[i] = mkVlan(12'(i), 3'd1);
    img[0] = mkUc(2'd1, 12'd0, 48'h10, 2'd0, 2'd1);
    img[1] = mkUc(2'd1, 12'd0, 48'h11, 2'd0, 2'd2);
    img[2] = mkMc(12'd0, 48'h0100_0000_0002, 3'b011);
    img[3] = mkMc(12'd0, 48'h0100_0000_0003, 3'b010);
    img[4] = mkUc(2'd3, 12'd1, 48'h14, 2'd3, 2'd3);
    loadImg();
    clearArgs(); cmd = 3'd4; portMask = 3'b010;
    runOne("R9 port flush");
    check(lat == 2 * Depth + 1, "R3 write-back adds no cycles", 72'(lat), 72'(2 * Depth + 1));
    check(mem[2][68:66] == 3'b001, "R9 multicast mask shrinks", 72'(mem[2][68:66]), 72'd1);
    check(mem[3][61:60] == 2'd0, "R9 multicast freed at empty mask", 72'(mem[3][61:60]), 72'd0);

    // R10: broadcast untouched, VLAN filter honoured
    for (int i = 0; i < Depth; i++) img[i] = '0;
    img[0] = mkMc(12'd5, 48'hFFFF_FFFF_FFFF, 3'b111);
    img[1] = mkMc(12'd5, 48'h0100_0000_0001, 3'b110);
    img[2] = mkMc(12'd6, 48'h0100_0000_0002, 3'b110);
    img[3] = mkUc(2'd1, 12'd5, 48'h33, 2'd1, 2'd1);
    loadImg();
    clearArgs(); cmd = 3'd5; portMask = 3'b111; vidFilter = 12'd5;
    runOne("R10 multicast flush vid 5");
    clearArgs(); cmd = 3'd5; portMask = 3'b100; vidFilter = 12'hFFF;
    runOne("R10 multicast flush all vids");

    // R11 R12: all-multicast set, then repeat is a no-op
    for (int i = 0; i < Depth; i++) img[i] = (i % 3 == 0) ? mkVlan(12'(i), 3'd6) : mkUc(2'd1, 12'd0, 48'(i), 2'd1, 2'd0);
    loadImg();
    clearArgs(); cmd = 3'd6; allMultiOn = 1'b1;
    runOne("R11 allmulti on");
    for (int i = 0; i < Depth; i++) img[i] = (i % 3 == 0) ? mkVlan(12'(i), 3'd2) : '0;
    loadImg();
    clearArgs(); cmd = 3'd6; allMultiOn = 1'b1;
    runOne("R11 allmulti repeat ignored");
    check(lat == 1, "R11 no-op completes at once", 72'(lat), 72'd1);
    clearArgs(); cmd = 3'd6; allMultiOn = 1'b0;
    runOne("R11 allmulti off");

    // R2: start while busy is ignored
    for (int i = 0; i < Depth; i++) img[i] = mkUc(2'd1, 12'd0, 48'(i + 1), 2'd1, 2'd0);
    loadImg();
    clearArgs(); cmd = 3'd0; keyMac = 48'h5; injectBusy = 1'b1;
    runOne("R2 busy start ignored");
    injectBusy = 1'b0;
    begin
      int extra = 0;
      repeat (40) begin @(negedge clk); if (done) extra++; end
      check(extra == 0, "R2 no second completion", 72'(extra), 72'd0);
    end

    // random mix
    for (int t = 0; t < 80; t++) begin
      for (int i = 0; i < Depth; i++) img[i] = rndEntry();
      loadImg();
      clearArgs();
      cmd = 3'($urandom % 7);
      keyMac = rndMac();
      keyVid = ($urandom % 2 == 0) ? 12'd5 : 12'd0;
      useVlan = 1'($urandom % 2);
      ucPort = 2'($urandom % 4);
      ucSecure = 1'($urandom % 2);
      ucBlocked = 1'($urandom % 2);
      portMask = 3'($urandom % 8);
      case ($urandom % 3)
        0: vidFilter = 12'd5;
        1: vidFilter = 12'd0;
        default: vidFilter = 12'hFFF;
      endcase
      allMultiOn = 1'($urandom % 2);
      runOne("R4 R5 R6 R7 R9 R10 R11 random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule